// File: doc/BRIEF.md
# Write-Leveling Feedback Responder

This block is a synthesizable, cycle-based stand-in for the memory-device side of write leveling. A leveling controller under test can close the loop through it without a real memory. While leveling is switched on, each rising edge of the data strobe takes a sample of the memory clock's current level. After a fixed number of cycles that sample appears on the data lanes. The controller sweeps its strobe delay and watches for the point where the feedback flips from 0 to 1.

Two feedback layouts are offered. In the first, one nominated lane carries the sample and every other lane is held low. In the second, every lane carries it. The layout is taken from a select input at the moment leveling is switched on. Around the start and the end of leveling the lanes have no defined value. The block models this by dropping the output-enable and forcing the lanes to zero. An exit hold of a programmable length has to run out before a new leveling session can begin.

All timing is counted in cycles of the block clock: the feedback latency, the enable delay and the exit hold. The strobe and the memory-clock level are sampled on that clock.

Top module: `wl_feedback_responder`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `dq_oe` is 0 and `dq` is all zero.
- R2: A strobe rising edge is seen at clock edge k when `dqs` is sampled 1 there and was sampled 0 at edge k-1. If it is accepted, the `ck_lvl` value sampled at edge k becomes the feedback bit after edge k+T_WLO.
- R3: The feedback bit holds its value until the next accepted strobe rising edge lands. Holding the strobe high, or changing `ck_lvl` between edges, has no effect on it.
- R4: When `lvl_en` is first sampled high at edge e with the block idle, `dq_oe` stays 0 through edge e+T_WLOE-1 and rises after edge e+T_WLOE. The feedback bit starts each session at 0.
- R5: In prime-lane layout (`all_lanes` = 0 at entry), lane PRIME of `dq` carries the feedback bit and all other lanes are 0 for the whole session.
- R6: In all-lane layout (`all_lanes` = 1 at entry), every bit of `dq` equals the feedback bit.
- R7: The layout is captured at the edge where leveling is entered. Changes to `all_lanes` later in the session have no effect on `dq`.
- R8: If `lvl_en` is sampled low at edge x during a session, `dq_oe` is 0 from edge x on. The block re-enters idle after edge x+T_MOD, and in that window `lvl_en` and strobe edges are ignored. Samples still in flight at exit are discarded.
- R9: Strobe edges that occur while `lvl_en` is low are not accepted and never reach `dq`.
- R10: Whenever `dq_oe` is 0, `dq` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dqs | input | 1 | Data strobe level (rising edges detected) |
| ck_lvl | input | 1 | Current level of the memory clock, sampled at strobe edges |
| lvl_en | input | 1 | Leveling enable |
| all_lanes | input | 1 | Feedback layout: 0 = prime lane only, 1 = all lanes |
| dq | output | LANES | Data lanes carrying the feedback |
| dq_oe | output | 1 | Lane output-enable; 0 models the undefined/tri-stated state |

## Verification
A stale feedback bit is visible on the lanes within one cycle of the point where the fresh sample should have landed. A wrong session state shows as `dq_oe` rising or falling a cycle early or late relative to the enable and exit counts. A layout latched at the wrong time, or a pipeline that is not flushed, shows up on the lanes at the first accepted strobe edge after the fault. The bench compares the lanes and the enable against a behavioural model on every cycle, so each of these faults is reported on the cycle it first appears at the ports.

// File: rtl/wl_fb_pkg.sv
package wl_fb_pkg;

    typedef enum logic [1:0] {
        WL_IDLE  = 2'd0,
        WL_WAIT  = 2'd1,
        WL_DRIVE = 2'd2,
        WL_EXIT  = 2'd3
    } wl_state_e;

    typedef struct packed {
        logic vld;
        logic lvl;
    } wl_sample_t;

    function automatic int wl_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int wl_cnt_width(input int top);
        return (top < 2) ? 1 : $clog2(top);
    endfunction

endpackage

// File: rtl/wl_strobe_capture.sv
module wl_strobe_capture
    import wl_fb_pkg::*;
#(
    parameter int T_WLO = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic dqs,
    input  logic ck_lvl,
    input  logic accept_ok,
    input  logic flush,
    output logic fb_bit
);

    logic       dqs_q;
    logic       strobe_rise;
    wl_sample_t stage [T_WLO];

    assign strobe_rise = dqs && !dqs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dqs_q <= 1'b0;
        end else begin
            dqs_q <= dqs;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            stage[0] <= '0;
        end else begin
            stage[0].vld <= strobe_rise && accept_ok;
            stage[0].lvl <= ck_lvl;
        end
    end

    for (genvar i = 1; i < T_WLO; i++) begin : g_delay
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                stage[i] <= '0;
            end else begin
                stage[i] <= stage[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            fb_bit <= 1'b0;
        end else if (stage[T_WLO-1].vld) begin
            fb_bit <= stage[T_WLO-1].lvl;
        end
    end

endmodule

// File: rtl/wl_session_fsm.sv
module wl_session_fsm
    import wl_fb_pkg::*;
#(
    parameter int T_WLOE = 4,
    parameter int T_MOD  = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_en,
    input  logic      all_lanes,
    output wl_state_e state,
    output logic      mode_all,
    output logic      accept_ok,
    output logic      flush,
    output logic      drive_on
);

    localparam int CNT_TOP = wl_max(T_WLOE, T_MOD);
    localparam int CW      = wl_cnt_width(CNT_TOP);
    localparam logic [CW-1:0] OE_LOAD  = CW'(T_WLOE - 1);
    localparam logic [CW-1:0] MOD_LOAD = CW'(T_MOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WL_IDLE;
            cnt      <= '0;
            mode_all <= 1'b0;
        end else begin
            unique case (state)
                WL_IDLE: begin
                    if (lvl_en) begin
                        state    <= WL_WAIT;
                        cnt      <= OE_LOAD;
                        mode_all <= all_lanes;
                    end
                end
                WL_WAIT: begin
                    if (!lvl_en) begin
                        state <= WL_EXIT;
                        cnt   <= MOD_LOAD;
                    end else if (cnt == '0) begin
                        state <= WL_DRIVE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                WL_DRIVE: begin
                    if (!lvl_en) begin
                        state <= WL_EXIT;
                        cnt   <= MOD_LOAD;
                    end
                end
                WL_EXIT: begin
                    if (cnt == '0) begin
                        state <= WL_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= WL_IDLE;
            endcase
        end
    end

    assign accept_ok = lvl_en && (state != WL_EXIT);
    assign flush     = (state == WL_EXIT);
    assign drive_on  = (state == WL_DRIVE);

endmodule

// File: rtl/wl_lane_driver.sv
module wl_lane_driver #(
    parameter int LANES = 8,
    parameter int PRIME = 0
) (
    input  logic             fb_bit,
    input  logic             mode_all,
    input  logic             drive_on,
    output logic [LANES-1:0] lanes
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == PRIME) begin : g_prime
            assign lanes[i] = drive_on && fb_bit;
        end else begin : g_other
            assign lanes[i] = drive_on && mode_all && fb_bit;
        end
    end

endmodule

// File: rtl/wl_feedback_responder.sv
module wl_feedback_responder
    import wl_fb_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int PRIME  = 0,
    parameter int T_WLO  = 6,
    parameter int T_WLOE = 4,
    parameter int T_MOD  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dqs,
    input  logic             ck_lvl,
    input  logic             lvl_en,
    input  logic             all_lanes,
    output logic [LANES-1:0] dq,
    output logic             dq_oe
);

    wl_state_e state;
    logic      mode_all;
    logic      accept_ok;
    logic      flush;
    logic      drive_on;
    logic      fb_bit;

    wl_session_fsm #(
        .T_WLOE (T_WLOE),
        .T_MOD  (T_MOD)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .lvl_en    (lvl_en),
        .all_lanes (all_lanes),
        .state     (state),
        .mode_all  (mode_all),
        .accept_ok (accept_ok),
        .flush     (flush),
        .drive_on  (drive_on)
    );

    wl_strobe_capture #(
        .T_WLO (T_WLO)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .dqs       (dqs),
        .ck_lvl    (ck_lvl),
        .accept_ok (accept_ok),
        .flush     (flush),
        .fb_bit    (fb_bit)
    );

    wl_lane_driver #(
        .LANES (LANES),
        .PRIME (PRIME)
    ) u_lanes (
        .fb_bit   (fb_bit),
        .mode_all (mode_all),
        .drive_on (drive_on),
        .lanes    (dq)
    );

    assign dq_oe = drive_on;

endmodule

// File: rtl/wl_feedback_checker.sv
module wl_feedback_checker #(
    parameter int LANES = 8,
    parameter int PRIME = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             lvl_en,
    input logic             mode_all,
    input logic [LANES-1:0] dq,
    input logic             dq_oe
);

    localparam logic [LANES-1:0] PRIME_MASK = LANES'(1) << PRIME;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!dq_oe && dq == '0));

    assert_enable_needed_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(lvl_en));

    assert_prime_only_R5: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && !mode_all) |-> ((dq & ~PRIME_MASK) == '0));

    assert_all_equal_R6: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && mode_all) |-> (dq == '0 || dq == '1));

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(dq_oe) && dq_oe) |-> $stable(mode_all));

    assert_exit_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && !lvl_en) |=> !dq_oe);

    assert_dq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq == '0));

endmodule

bind wl_feedback_responder wl_feedback_checker #(
    .LANES (LANES),
    .PRIME (PRIME)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lvl_en   (lvl_en),
    .mode_all (mode_all),
    .dq       (dq),
    .dq_oe    (dq_oe)
);

// File: tb/wl_feedback_responder_test.sv
module wl_feedback_responder_test;

    localparam int LANES  = 8;
    localparam int PRIME  = 0;
    localparam int T_WLO  = 6;
    localparam int T_WLOE = 4;
    localparam int T_MOD  = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             dqs = 1'b0;
    logic             ck_lvl = 1'b0;
    logic             lvl_en = 1'b0;
    logic             all_lanes = 1'b0;
    logic [LANES-1:0] dq;
    logic             dq_oe;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";
    bit    done     = 1'b0;

    // behavioural reference state
    int  m_state = 0;   // 0 idle, 1 wait, 2 drive, 3 exit
    int  m_cnt   = 0;
    bit  m_mode  = 1'b0;
    bit  m_fb    = 1'b0;
    bit  m_prev  = 1'b0;
    int  cyc     = 0;
    int  due_q[$];
    bit  val_q[$];

    wl_feedback_responder #(
        .LANES (LANES), .PRIME (PRIME), .T_WLO (T_WLO),
        .T_WLOE (T_WLOE), .T_MOD (T_MOD)
    ) uut (
        .clk (clk), .rst (rst), .dqs (dqs), .ck_lvl (ck_lvl),
        .lvl_en (lvl_en), .all_lanes (all_lanes), .dq (dq), .dq_oe (dq_oe)
    );

    always #4 clk = ~clk;

    function automatic logic [LANES-1:0] lane_pat(input bit v, input bit all_m, input bit oe);
        logic [LANES-1:0] p;
        if (!oe || !v) p = '0;
        else if (all_m) p = '1;
        else p = LANES'(1) << PRIME;
        return p;
    endfunction

    task automatic check(input string tag, input logic [LANES-1:0] exp_dq, input logic exp_oe);
        n_checks++;
        if (dq !== exp_dq || dq_oe !== exp_oe) begin
            n_fail++;
            $display("FAIL %s: dq=%h oe=%b expected dq=%h oe=%b (cycle %0d)",
                     tag, dq, dq_oe, exp_dq, exp_oe, cyc);
        end
    endtask

    // reference model, stepped on every rising edge, compared 2 ns later
    always @(posedge clk) begin
        bit rise;
        bit accept;
        int old;
        cyc++;
        if (rst) begin
            m_state = 0; m_cnt = 0; m_mode = 0; m_fb = 0; m_prev = 0;
            due_q.delete(); val_q.delete();
        end else begin
            old    = m_state;
            rise   = dqs && !m_prev;
            m_prev = dqs;
            accept = rise && lvl_en && (old != 3);
            if (old == 3) begin
                due_q.delete(); val_q.delete(); m_fb = 0;
            end else begin
                while (due_q.size() > 0 && due_q[0] == cyc) begin
                    m_fb = val_q[0];
                    void'(due_q.pop_front()); void'(val_q.pop_front());
                end
                if (accept) begin
                    due_q.push_back(cyc + T_WLO); val_q.push_back(ck_lvl);
                end
            end
            case (old)
                0: if (lvl_en) begin m_state = 1; m_cnt = T_WLOE - 1; m_mode = all_lanes; end
                1, 2: begin
                    if (!lvl_en) begin m_state = 3; m_cnt = T_MOD - 1; end
                    else if (old == 1) begin
                        if (m_cnt == 0) m_state = 2; else m_cnt--;
                    end
                end
                default: if (m_cnt == 0) m_state = 0; else m_cnt--;
            endcase
        end
        #2;
        if (!done) check({"cycle ", phase}, lane_pat(m_fb, m_mode, m_state == 2), m_state == 2);
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one strobe pulse; checks the old value just before and the new value at landing
    task automatic probe(input bit v, input bit old_v, input bit all_m, input string tag);
        ck_lvl = v; dqs = 1'b1;
        tick(1);
        dqs = 1'b0; ck_lvl = ~v;
        tick(T_WLO - 1);
        check({tag, " before landing"}, lane_pat(old_v, all_m, 1'b1), 1'b1);
        tick(1);
        check({tag, " landed"}, lane_pat(v, all_m, 1'b1), 1'b1);
        tick(2);
    endtask

    initial begin
        tick(3);
        check("R1 reset", '0, 1'b0);
        rst = 1'b0;
        tick(1);
        check("R1 after reset", '0, 1'b0);

        // R9: strobes with leveling off
        phase = "R9";
        for (int i = 0; i < 3; i++) begin
            ck_lvl = 1'b1; dqs = 1'b1; tick(1); dqs = 1'b0; tick(2);
        end
        check("R9 idle strobes", '0, 1'b0);

        // R4: enter prime-lane session
        phase = "R4";
        all_lanes = 1'b0; lvl_en = 1'b1;
        tick(T_WLOE);
        check("R4 enable not yet", '0, 1'b0);
        check("R10 lanes quiet while disabled", '0, 1'b0);
        tick(1);
        check("R4 enable on, feedback starts 0", '0, 1'b1);

        phase = "R2";
        probe(1'b1, 1'b0, 1'b0, "R2 capture high");
        probe(1'b0, 1'b1, 1'b0, "R2 capture low");
        phase = "R5";
        probe(1'b1, 1'b0, 1'b0, "R5 prime lane");

        // R3: strobe held high, clock level toggled
        phase = "R3";
        ck_lvl = 1'b0; dqs = 1'b1;
        for (int i = 0; i < T_WLO + 4; i++) begin tick(1); ck_lvl = ~ck_lvl; end
        dqs = 1'b0;
        tick(T_WLO + 2);
        check("R3 hold through long strobe", lane_pat(1'b0, 1'b0, 1'b1), 1'b1);

        // R7: layout change mid-session ignored
        phase = "R7";
        all_lanes = 1'b1;
        probe(1'b1, 1'b0, 1'b0, "R7 layout kept");

        // R8: exit with a sample in flight
        phase = "R8";
        ck_lvl = 1'b0; dqs = 1'b1; tick(1); dqs = 1'b0;
        lvl_en = 1'b0;
        tick(1);
        check("R8 enable drops at exit", '0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            ck_lvl = 1'b1; dqs = 1'b1; tick(1); dqs = 1'b0; tick(1);
        end
        lvl_en = 1'b1;   // raised inside the exit hold
        all_lanes = 1'b1;
        tick(T_MOD - 6);
        check("R8 still held off", '0, 1'b0);
        tick(T_WLOE + 4);

        // R6: all-lane session entered at end of hold
        phase = "R6";
        check("R8 new session feedback 0", '0, 1'b1);
        probe(1'b1, 1'b0, 1'b1, "R6 all lanes");
        probe(1'b0, 1'b1, 1'b1, "R6 all lanes low");

        phase = "R10";
        lvl_en = 1'b0;
        tick(T_MOD + 3);
        check("R10 idle after exit", '0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        tick(100000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule